// File: doc/BRIEF.md
# Recirculating Serial/Parallel Shift-and-Store Register

The block combines a serial shift register with a parallel storage register of the same width. One bidirectional serial line is modelled as three signals: an input, an output and an output enable. A select input (active low) and a direction input decide what happens on each falling edge of the shift clock.

- With direction low, the bit on the serial input is shifted in.
- With direction high and the store clock low, the outgoing bit is driven onto the serial line and also fed back into the register, so the contents rotate.
- With direction high and the store clock high, the shift register is loaded from the storage register.

A rising edge of the store clock copies the shift register into the storage register, which drives the parallel outputs. This copy happens only when select and direction are both low.

Everything runs on one system clock. The shift clock and the store clock are synchronised and turned into one-cycle strobes. An active-low clear empties the storage register at once and overrides any store in progress.

Top module: `sio_shift_store`

## Requirements
- R1: After system reset the parallel outputs are all zero.
- R2: While select is high, shift-clock and store-clock edges change neither register, and the serial output enable is low.
- R3: With select low and direction low, each shift-clock falling edge moves every bit one place toward bit 15 and puts the serial input into bit 0.
- R4: With select low, direction high and the store clock low, each shift-clock falling edge rotates the register: bit 15 is presented on the serial output and re-enters at bit 0, so 16 shifts leave the contents unchanged.
- R5: With select low, direction high and the store clock high, a shift-clock falling edge loads the shift register from the storage register without shifting.
- R6: A store-clock rising edge copies the shift register into the storage register only when select and direction are both low. In every other case the storage register holds its value.
- R7: The active-low store clear forces the parallel outputs to zero asynchronously, and a store edge while it is low leaves them at zero.
- R8: A shift-clock rising edge and a store-clock falling edge change nothing, and each qualifying edge acts exactly once.
- R9: The serial output enable is high exactly when select is low and direction is high. The serial output always carries bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| sel_n | input | 1 | Block select, active low |
| dir_rd | input | 1 | Direction: 1 drive out and rotate, 0 take in |
| sh_clk | input | 1 | Shift clock; acts on its falling edge |
| st_clk | input | 1 | Store clock; acts on its rising edge |
| st_clr_n | input | 1 | Asynchronous active-low clear of the storage register |
| ser_in | input | 1 | Serial data from the shared line |
| ser_out | output | 1 | Serial data toward the shared line (bit 15) |
| ser_oe | output | 1 | Drive enable for the shared line |
| par_q | output | WIDTH | Parallel outputs of the storage register |

## Verification
The bench shifts in two words with irregular bit patterns and reads them back by rotation. A single set bit is walked in to expose the bit ordering and the entry position. A wrong shift direction or a lost end bit garbles the readback. A swapped entry end turns the walked bit into the wrong parallel value.

Store edges are tried with direction high, with select high and under clear. Only the legal case may change the outputs, so these cases separate the store qualification from the clear priority. A reload after a different word has been shifted in shows that the reload path overwrites the register rather than shifting.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;

  typedef enum logic [1:0] {
    SH_HOLD   = 2'd0,
    SH_TAKE   = 2'd1,
    SH_ROTATE = 2'd2,
    SH_RELOAD = 2'd3
  } sh_mode_e;

  function automatic sh_mode_e decode_mode(input logic sel_n,
                                           input logic dir_rd,
                                           input logic st_lvl);
    sh_mode_e m;
    if (sel_n)        m = SH_HOLD;
    else if (!dir_rd) m = SH_TAKE;
    else if (st_lvl)  m = SH_RELOAD;
    else              m = SH_ROTATE;
    return m;
  endfunction

endpackage

// File: rtl/sio_rst_sync.sv
`timescale 1ns/1ps
module sio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/sio_edge_strobe.sv
`timescale 1ns/1ps
module sio_edge_strobe #(
  parameter int   STAGES = 2,
  parameter logic RISE   = 1'b1,
  parameter logic IDLE   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic strobe
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_in};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {STAGES{IDLE}};
      prev_q <= IDLE;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign level = sync_q[STAGES-1];

  generate
    if (RISE) begin : g_rise
      assign strobe = level & ~prev_q;
    end else begin : g_fall
      assign strobe = ~level & prev_q;
    end
  endgenerate

  // R8: one strobe per edge
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
endmodule

// File: rtl/sio_shift_core.sv
`timescale 1ns/1ps
module sio_shift_core
  import sio_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_stb,
  input  logic             sel_n,
  input  logic             dir_rd,
  input  logic             st_lvl,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] store_q,
  output logic [WIDTH-1:0] sh_q
);
  localparam int MSB = WIDTH - 1;

  sh_mode_e         mode;
  logic [WIDTH-1:0] sh_d;
  logic             sh_en;

  always_comb begin
    mode  = decode_mode(sel_n, dir_rd, st_lvl);
    sh_en = shift_stb && (mode != SH_HOLD);
    unique case (mode)
      SH_TAKE:   sh_d = {sh_q[MSB-1:0], ser_in};
      SH_ROTATE: sh_d = {sh_q[MSB-1:0], sh_q[MSB]};
      SH_RELOAD: sh_d = store_q;
      default:   sh_d = sh_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assert_sel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_stb && sel_n) |=> $stable(sh_q));
  assert_rotate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_stb && !sel_n && dir_rd && !st_lvl) |=>
      (sh_q == {$past(sh_q[MSB-1:0]), $past(sh_q[MSB])}));
  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_stb && !sel_n && dir_rd && st_lvl) |=> (sh_q == $past(store_q)));
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_stb |=> $stable(sh_q));
endmodule

// File: rtl/sio_store_reg.sv
`timescale 1ns/1ps
module sio_store_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_d;

  always_comb q_d = load_en ? din : q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= q_d;
  end

  assert_store_hold_R6: assert property (@(posedge clk) disable iff (!clr_n)
    !load_en |=> $stable(q));
endmodule

// File: rtl/sio_shift_store.sv
`timescale 1ns/1ps
module sio_shift_store #(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             dir_rd,
  input  logic             sh_clk,
  input  logic             st_clk,
  input  logic             st_clr_n,
  input  logic             ser_in,
  output logic             ser_out,
  output logic             ser_oe,
  output logic [WIDTH-1:0] par_q
);
  localparam int MSB = WIDTH - 1;

  logic             sys_rst_n;
  logic             st_rst_n;
  logic             sh_lvl, sh_stb;
  logic             st_lvl, st_stb;
  logic             store_en;
  logic [WIDTH-1:0] sh_q;

  sio_rst_sync #(.STAGES(SYNC_STAGES)) u_sys_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(sys_rst_n));

  sio_rst_sync #(.STAGES(SYNC_STAGES)) u_st_rst (
    .clk(clk), .arst_n(rst_n & st_clr_n), .srst_n(st_rst_n));

  sio_edge_strobe #(.STAGES(SYNC_STAGES), .RISE(1'b0), .IDLE(1'b1)) u_sh_edge (
    .clk(clk), .rst_n(sys_rst_n), .async_in(sh_clk),
    .level(sh_lvl), .strobe(sh_stb));

  sio_edge_strobe #(.STAGES(SYNC_STAGES), .RISE(1'b1), .IDLE(1'b0)) u_st_edge (
    .clk(clk), .rst_n(sys_rst_n), .async_in(st_clk),
    .level(st_lvl), .strobe(st_stb));

  sio_shift_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(sys_rst_n), .shift_stb(sh_stb),
    .sel_n(sel_n), .dir_rd(dir_rd), .st_lvl(st_lvl),
    .ser_in(ser_in), .store_q(par_q), .sh_q(sh_q));

  always_comb store_en = st_stb & ~sel_n & ~dir_rd;

  sio_store_reg #(.WIDTH(WIDTH)) u_store (
    .clk(clk), .clr_n(st_rst_n), .load_en(store_en),
    .din(sh_q), .q(par_q));

  assign ser_out = sh_q[MSB];
  assign ser_oe  = ~sel_n & dir_rd;

  assert_store_copy_R6: assert property (@(posedge clk) disable iff (!st_rst_n)
    (st_stb && !sel_n && !dir_rd) |=> (par_q == $past(sh_q)));
  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !st_clr_n |-> (par_q == '0));
  assert_oe_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> !ser_oe);
  assert_oe_follows_R9: assert property (@(posedge clk) disable iff (!sys_rst_n)
    ser_oe |-> (ser_out == sh_q[MSB]));
endmodule

// File: tb/sio_shift_store_tb_top.sv
`timescale 1ns/1ps
module sio_shift_store_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n, sel_n, dir_rd, sh_clk, st_clk, st_clr_n, ser_in;
  logic ser_out, ser_oe;
  logic [W-1:0] par_q;

  always #2.5 clk = ~clk;

  sio_shift_store #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .dir_rd(dir_rd),
    .sh_clk(sh_clk), .st_clk(st_clk), .st_clr_n(st_clr_n),
    .ser_in(ser_in), .ser_out(ser_out), .ser_oe(ser_oe), .par_q(par_q));

  typedef struct {
    string      req;
    int         kind;   // 0 parallel, 1 enable, 2 serial readback
    logic [W-1:0] exp;
  } item_t;

  item_t        sb_q[$];
  event         sample_ev;
  logic [W-1:0] rd_word;
  int           n_chk = 0;
  int           n_bad = 0;
  bit           done  = 0;

  // monitor
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [W-1:0] act;
        it  = sb_q.pop_front();
        act = (it.kind == 0) ? par_q : (it.kind == 1) ? {{(W-1){1'b0}}, ser_oe} : rd_word;
        n_chk++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic expect_item(input string req, input int kind, input logic [W-1:0] val);
    item_t it;
    it.req = req; it.kind = kind; it.exp = val;
    sb_q.push_back(it);
    -> sample_ev;
    #0.5;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sh_pulse();
    sh_clk = 1'b0; cyc(4);
    sh_clk = 1'b1; cyc(4);
  endtask

  task automatic shift_word(input logic [W-1:0] v);
    for (int i = W - 1; i >= 0; i--) begin
      ser_in = v[i];
      sh_pulse();
    end
  endtask

  task automatic read_word();
    rd_word = '0;
    for (int i = 0; i < W; i++) begin
      rd_word = {rd_word[W-2:0], ser_out};
      sh_pulse();
    end
  endtask

  task automatic st_rise(); st_clk = 1'b1; cyc(5); endtask
  task automatic st_fall(); st_clk = 1'b0; cyc(5); endtask

  initial begin
    rst_n = 0; sel_n = 1; dir_rd = 0; sh_clk = 1; st_clk = 0;
    st_clr_n = 1; ser_in = 0;
    cyc(4); rst_n = 1; cyc(6);
    expect_item("R1", 0, '0);
    expect_item("R9", 1, 16'h0);

    sel_n = 0; dir_rd = 0; cyc(2);
    shift_word(16'hA5C3);
    expect_item("R9", 1, 16'h0);
    expect_item("R6", 0, '0);
    st_rise();
    expect_item("R3", 0, 16'hA5C3);
    st_fall();
    expect_item("R8", 0, 16'hA5C3);

    dir_rd = 1; cyc(2);
    expect_item("R9", 1, 16'h1);
    read_word();
    expect_item("R4", 2, 16'hA5C3);
    read_word();
    expect_item("R4", 2, 16'hA5C3);

    st_rise();
    expect_item("R6", 0, 16'hA5C3);
    st_fall();
    dir_rd = 0; cyc(2);
    shift_word(16'h1234);
    expect_item("R6", 0, 16'hA5C3);
    dir_rd = 1; cyc(2);
    read_word();
    expect_item("R3", 2, 16'h1234);

    st_rise();
    sh_pulse();
    st_fall();
    read_word();
    expect_item("R5", 2, 16'hA5C3);

    sel_n = 1; dir_rd = 0; ser_in = 1; cyc(2);
    expect_item("R2", 1, 16'h0);
    sh_pulse(); sh_pulse(); sh_pulse();
    st_rise(); st_fall();
    expect_item("R2", 0, 16'hA5C3);
    sel_n = 0; dir_rd = 1; cyc(2);
    read_word();
    expect_item("R2", 2, 16'hA5C3);

    st_clr_n = 0; #1;
    expect_item("R7", 0, '0);
    dir_rd = 0; cyc(2);
    st_rise();
    expect_item("R7", 0, '0);
    st_fall();
    st_clr_n = 1; cyc(5);
    expect_item("R7", 0, '0);
    st_rise();
    expect_item("R6", 0, 16'hA5C3);
    st_fall();

    shift_word(16'h0000);
    ser_in = 1; sh_pulse();
    st_rise();
    expect_item("R3", 0, 16'h0001);
    st_fall();
    ser_in = 0; sh_pulse();
    st_rise();
    expect_item("R3", 0, 16'h0002);
    st_fall();

    cyc(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule